// File: doc/BRIEF.md
# Low-Power Lane Sequence Decoder

This block watches the two single-ended line levels of one serial data lane while the lane is in low-power signalling. It leaves reset waiting for the Stop level and follows multi-step line-state sequences from there. It recognises requests for high-speed transfer, bus turnaround and escape mode. Inside escape mode it decodes spaced-one-hot symbols into an 8-bit command byte and then into data bytes. It leaves escape mode on the exit sequence, and it follows the ultra-low-power state through entry and a timed wake-up.

Only changes of the line pair matter. Each line state may be held for any number of clock cycles, and a repeated sample of the same state is not a new event. The lines are taken to be already synchronised to `clk`. The `tick` input is a periodic strobe, for example one pulse per microsecond, that paces the wake-up timer. Mode flags are registered levels. Bytes, turnaround requests and errors are reported as one-cycle pulses. The line pair is written as LP-xy, with x the positive line (`lp_lines[1]`) and y the negative line (`lp_lines[0]`).

Top module: `lp_lane_decoder`

## Requirements
- R1: During reset and until LP-11 is first seen, no mode flag and no pulse is set. Once LP-11 is present after reset, `stop_o` rises.
- R2: From Stop, the sequence LP-01 then LP-00 raises `hs_o`. While `hs_o` is high, every line state other than LP-11 is ignored. LP-11 clears `hs_o` and returns to Stop.
- R3: From Stop, the sequence LP-10, LP-00, LP-10, LP-00 gives one `bta_o` pulse. The decoder then waits for LP-11 before it shows Stop again.
- R4: From Stop, the sequence LP-10, LP-00, LP-01, LP-00 raises `esc_o`.
- R5: In escape mode, LP-01 (Mark-0) is a zero and LP-10 (Mark-1) is a one, and each Mark must be followed by LP-00. Bits arrive least significant first. The first 8 bits are presented on `cmd_o` together with a one-cycle `cmd_valid_o`.
- R6: Each further group of 8 bits after the command is presented on `data_o` together with a one-cycle `data_valid_o`.
- R7: LP-10 followed by LP-11 leaves escape mode and returns to Stop. Any incomplete byte is dropped.
- R8: A Mark followed directly by the other Mark gives a `bit_err_o` pulse, clears `esc_o`, and makes the decoder wait for LP-11.
- R9: A line state that does not fit the current sequence gives a `seq_err_o` pulse, clears all mode flags, and makes the decoder wait for LP-11.
- R10: A command byte equal to parameter `ULPS_CMD` (default 8'h1E) clears `esc_o` and raises `ulps_o` in the same cycle as `cmd_valid_o`.
- R11: In ultra-low-power state, LP-10 starts a wake-up count of `WAKE_TICKS` ticks. LP-11 after the count has run out returns to Stop. LP-11 earlier than that, or any other line state, gives `seq_err_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_lines | input | 2 | Sampled line pair, [1] positive line, [0] negative line |
| tick | input | 1 | Timer strobe for the wake-up count |
| stop_o | output | 1 | Lane is in Stop state |
| hs_o | output | 1 | High-speed transfer in progress |
| esc_o | output | 1 | Escape mode active |
| ulps_o | output | 1 | Ultra-low-power state, including wake-up |
| bta_o | output | 1 | Turnaround request pulse |
| cmd_valid_o | output | 1 | Command byte pulse |
| cmd_o | output | 8 | Last escape command byte |
| data_valid_o | output | 1 | Data byte pulse |
| data_o | output | 8 | Last escape data byte |
| seq_err_o | output | 1 | Sequence error pulse |
| bit_err_o | output | 1 | Symbol decoding error pulse |

## Verification
The bench builds the decoder with `WAKE_TICKS` set to 6 and drives a tick every third clock. With these values both a wake-up that ends too early and one that lasts long enough fit in a few dozen cycles, instead of a millisecond. `ULPS_CMD` keeps its default value. The random command bytes sent to the decoder therefore skip that one value, which is tested in directed cases. Hold times of the line states are drawn at random, so the decoder is shown to depend on changes of the lines and not on how long each state lasts.

// File: rtl/lp_lane_decoder.sv
module lp_lane_decoder #(
  parameter int          WAKE_TICKS = 1000,
  parameter logic [7:0]  ULPS_CMD   = 8'h1E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lp_lines,
  input  logic       tick,
  output logic       stop_o,
  output logic       hs_o,
  output logic       esc_o,
  output logic       ulps_o,
  output logic       bta_o,
  output logic       cmd_valid_o,
  output logic [7:0] cmd_o,
  output logic       data_valid_o,
  output logic [7:0] data_o,
  output logic       seq_err_o,
  output logic       bit_err_o
);
  localparam int CW = $clog2(WAKE_TICKS + 1);
  localparam logic [1:0] L00 = 2'b00, L01 = 2'b01, L10 = 2'b10, L11 = 2'b11;

  typedef enum logic [3:0] {
    WAIT_STOP, STOP, HS_REQ, HS_ON, ENT_A, ENT_B, ENT_ESC, ENT_BTA,
    SPACE, MARK, ULPS, WAKE
  } st_t;

  st_t st, nst;
  logic [1:0]    prev;
  logic [CW-1:0] cnt;
  logic [7:0]    bits;
  logic [2:0]    nbit;
  logic          have_cmd;
  logic          serr, berr, take, bta, wake_ld;

  wire       chg      = lp_lines != prev;
  wire [7:0] newbyte  = {prev == L10, bits[7:1]};
  wire       byte_end = take && nbit == 3'd7;

  assign stop_o = st == STOP;
  assign hs_o   = st == HS_ON;
  assign esc_o  = st == SPACE || st == MARK;
  assign ulps_o = st == ULPS || st == WAKE;

  always_comb begin
    nst = st; serr = 1'b0; berr = 1'b0; take = 1'b0; bta = 1'b0; wake_ld = 1'b0;
    if (st == WAIT_STOP) begin
      if (lp_lines == L11) nst = STOP;
    end else if (chg) begin
      case (st)
        STOP:    if (lp_lines == L10) nst = ENT_A;
                 else if (lp_lines == L01) nst = HS_REQ;
                 else serr = 1'b1;
        HS_REQ:  if (lp_lines == L00) nst = HS_ON; else serr = 1'b1;
        HS_ON:   if (lp_lines == L11) nst = STOP;
        ENT_A:   if (lp_lines == L00) nst = ENT_B; else serr = 1'b1;
        ENT_B:   if (lp_lines == L01) nst = ENT_ESC;
                 else if (lp_lines == L10) nst = ENT_BTA;
                 else serr = 1'b1;
        ENT_ESC: if (lp_lines == L00) nst = SPACE; else serr = 1'b1;
        ENT_BTA: if (lp_lines == L00) begin bta = 1'b1; nst = WAIT_STOP; end
                 else serr = 1'b1;
        SPACE:   if (lp_lines == L01 || lp_lines == L10) nst = MARK; else serr = 1'b1;
        MARK:    if (lp_lines == L00) begin
                   take = 1'b1;
                   nst  = SPACE;
                   if (nbit == 3'd7 && !have_cmd && newbyte == ULPS_CMD) nst = ULPS;
                 end else if (lp_lines == L11) begin
                   if (prev == L10) nst = STOP; else serr = 1'b1;
                 end else begin
                   berr = 1'b1;
                   nst  = WAIT_STOP;
                 end
        ULPS:    if (lp_lines == L10) begin nst = WAKE; wake_ld = 1'b1; end
                 else serr = 1'b1;
        WAKE:    if (lp_lines == L11 && cnt == '0) nst = STOP; else serr = 1'b1;
        default: serr = 1'b1;
      endcase
      if (serr) nst = WAIT_STOP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= WAIT_STOP;
      prev         <= L11;
      cnt          <= '0;
      bits         <= '0;
      nbit         <= '0;
      have_cmd     <= 1'b0;
      cmd_o        <= '0;
      data_o       <= '0;
      cmd_valid_o  <= 1'b0;
      data_valid_o <= 1'b0;
      seq_err_o    <= 1'b0;
      bit_err_o    <= 1'b0;
      bta_o        <= 1'b0;
    end else begin
      st           <= nst;
      prev         <= lp_lines;
      seq_err_o    <= serr;
      bit_err_o    <= berr;
      bta_o        <= bta;
      cmd_valid_o  <= byte_end && !have_cmd;
      data_valid_o <= byte_end && have_cmd;
      if (wake_ld) cnt <= CW'(WAKE_TICKS);
      else if (st == WAKE && tick && cnt != '0) cnt <= cnt - 1'b1;
      if (take) begin
        bits <= newbyte;
        nbit <= nbit + 3'd1;
      end
      if (byte_end) begin
        if (have_cmd) data_o <= newbyte;
        else          cmd_o  <= newbyte;
        have_cmd <= 1'b1;
      end
      if (nst != SPACE && nst != MARK) begin
        nbit     <= '0;
        have_cmd <= 1'b0;
      end
    end
  end
endmodule

module lp_lane_decoder_chk #(
  parameter logic [7:0] ULPS_CMD = 8'h1E
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] lp_lines,
  input logic       stop_o,
  input logic       hs_o,
  input logic       esc_o,
  input logic       ulps_o,
  input logic       bta_o,
  input logic       cmd_valid_o,
  input logic [7:0] cmd_o,
  input logic       seq_err_o,
  input logic       bit_err_o
);
  assert_hs_entry_on_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_o) |-> $past(lp_lines) == 2'b00);
  assert_bta_on_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bta_o |-> ($past(lp_lines) == 2'b00 && !stop_o));
  assert_cmd_in_escape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (esc_o || ulps_o));
  assert_escape_leaves_cleanly_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(esc_o) |-> (stop_o || ulps_o || seq_err_o || bit_err_o));
  assert_bit_error_abandons_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err_o |-> (!esc_o && !stop_o));
  assert_seq_error_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err_o |-> (!esc_o && !hs_o && !ulps_o && !stop_o));
  assert_ulps_by_command_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ulps_o) |-> (cmd_valid_o && cmd_o == ULPS_CMD));
  assert_ulps_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ulps_o) |-> (stop_o || seq_err_o));
endmodule

bind lp_lane_decoder lp_lane_decoder_chk #(.ULPS_CMD(ULPS_CMD)) u_chk (
  .clk(clk), .rst_n(rst_n), .lp_lines(lp_lines), .stop_o(stop_o), .hs_o(hs_o),
  .esc_o(esc_o), .ulps_o(ulps_o), .bta_o(bta_o), .cmd_valid_o(cmd_valid_o),
  .cmd_o(cmd_o), .seq_err_o(seq_err_o), .bit_err_o(bit_err_o)
);

// File: tb/lp_lane_decoder_test.sv
module lp_lane_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WT = 6;
  localparam logic [7:0] ULPS = 8'h1E;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [1:0] lp_lines = 2'b11;
  logic stop_o, hs_o, esc_o, ulps_o, bta_o, cmd_valid_o, data_valid_o, seq_err_o, bit_err_o;
  logic [7:0] cmd_o, data_o;

  int n_chk = 0, n_fail = 0, tdiv = 0;
  int seq_n = 0, bit_n = 0, bta_n = 0, cmd_n = 0;
  logic [7:0] last_cmd = '0;
  logic [7:0] data_q[$];
  bit done = 1'b0;

  lp_lane_decoder #(.WAKE_TICKS(WT), .ULPS_CMD(ULPS)) uut (
    .clk(clk), .rst_n(rst_n), .lp_lines(lp_lines), .tick(tick),
    .stop_o(stop_o), .hs_o(hs_o), .esc_o(esc_o), .ulps_o(ulps_o), .bta_o(bta_o),
    .cmd_valid_o(cmd_valid_o), .cmd_o(cmd_o), .data_valid_o(data_valid_o),
    .data_o(data_o), .seq_err_o(seq_err_o), .bit_err_o(bit_err_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tdiv == 2) begin tdiv = 0; tick = 1'b1; end
    else begin tdiv = tdiv + 1; tick = 1'b0; end
    if (seq_err_o) seq_n = seq_n + 1;
    if (bit_err_o) bit_n = bit_n + 1;
    if (bta_o) bta_n = bta_n + 1;
    if (cmd_valid_o) begin cmd_n = cmd_n + 1; last_cmd = cmd_o; end
    if (data_valid_o) data_q.push_back(data_o);
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int hold();
    return 1 + int'($urandom % 3);
  endfunction

  task automatic put(logic [1:0] v, int h);
    @(negedge clk);
    lp_lines = v;
    repeat (h) @(negedge clk);
  endtask

  task automatic go_stop();
    put(2'b11, 3);
  endtask

  task automatic esc_enter();
    put(2'b10, hold()); put(2'b00, hold()); put(2'b01, hold()); put(2'b00, hold());
  endtask

  task automatic send_byte(logic [7:0] b, int nb);
    for (int i = 0; i < nb; i++) begin
      put(b[i] ? 2'b10 : 2'b01, hold());
      put(2'b00, hold());
    end
  endtask

  task automatic esc_exit();
    put(2'b10, hold()); put(2'b11, hold());
  endtask

  function automatic logic [7:0] rnd_cmd();
    logic [7:0] c = 8'($urandom);
    if (c == ULPS) c = c ^ 8'h01;
    return c;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int s0, b0, t0, c0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 flags in reset", {stop_o, hs_o, esc_o, ulps_o}, 0);
    check("R1 pulses in reset", {bta_o, cmd_valid_o, data_valid_o, seq_err_o, bit_err_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 stop after reset", stop_o, 1);

    // R2 high-speed request
    s0 = seq_n;
    put(2'b01, hold()); put(2'b00, hold());
    check("R2 hs flag", hs_o, 1);
    put(2'b01, 2); put(2'b10, 2); put(2'b00, 2);
    check("R2 ignore in hs", hs_o, 1);
    check("R2 no error in hs", seq_n - s0, 0);
    put(2'b11, 2);
    check("R2 hs exit to stop", {hs_o, stop_o}, 1);

    // R3 turnaround
    t0 = bta_n;
    put(2'b10, hold()); put(2'b00, hold()); put(2'b10, hold()); put(2'b00, 2);
    check("R3 bta pulse", bta_n - t0, 1);
    check("R3 waits for stop", stop_o, 0);
    go_stop();
    check("R3 stop again", stop_o, 1);

    // R4..R7 random escape sessions
    for (int it = 0; it < 25; it++) begin
      logic [7:0] c, exp_d[$];
      int nd;
      c = rnd_cmd(); nd = int'($urandom % 4);
      c0 = cmd_n; data_q.delete(); s0 = seq_n;
      esc_enter();
      check("R4 escape flag", esc_o, 1);
      send_byte(c, 8);
      for (int k = 0; k < nd; k++) begin
        logic [7:0] d = 8'($urandom);
        exp_d.push_back(d);
        send_byte(d, 8);
      end
      if (it % 3 == 0) send_byte(8'($urandom), 1 + int'($urandom % 7));
      esc_exit();
      check("R5 one command", cmd_n - c0, 1);
      check("R5 command value", last_cmd, c);
      check("R6 data count", data_q.size(), nd);
      for (int k = 0; k < nd && k < data_q.size(); k++)
        check("R6 data value", data_q[k], exp_d[k]);
      check("R7 exit to stop", {esc_o, stop_o}, 1);
      check("R7 no error", seq_n - s0, 0);
    end

    // R8 mark without space
    b0 = bit_n;
    esc_enter();
    put(2'b01, hold()); put(2'b10, 2);
    check("R8 bit error", bit_n - b0, 1);
    check("R8 escape dropped", {esc_o, stop_o}, 0);
    go_stop();
    check("R8 recovers", stop_o, 1);

    // R9 sequence errors
    s0 = seq_n;
    put(2'b00, 2);
    check("R9 stop to 00", seq_n - s0, 1);
    check("R9 idle after error", {stop_o, hs_o, esc_o, ulps_o}, 0);
    go_stop();
    s0 = seq_n; put(2'b01, 1); put(2'b10, 2);
    check("R9 hs request broken", seq_n - s0, 1);
    go_stop();
    s0 = seq_n; put(2'b10, 1); put(2'b11, 2);
    check("R9 entry broken", seq_n - s0, 1);
    check("R9 back to stop", stop_o, 1);
    s0 = seq_n; put(2'b10, 1); put(2'b00, 1); put(2'b01, 1); put(2'b11, 2);
    check("R9 escape entry broken", seq_n - s0, 1);
    go_stop();

    // R10 / R11 ultra-low-power
    c0 = cmd_n; s0 = seq_n;
    esc_enter(); send_byte(ULPS, 8);
    check("R10 command seen", cmd_n - c0, 1);
    check("R10 ulps flag", {esc_o, ulps_o}, 1);
    put(2'b10, 4); put(2'b11, 2);
    check("R11 short wake error", seq_n - s0, 1);
    check("R11 short wake leaves ulps", ulps_o, 0);
    go_stop();
    s0 = seq_n;
    esc_enter(); send_byte(ULPS, 8);
    put(2'b10, 30);
    check("R11 still ulps in wake", ulps_o, 1);
    put(2'b11, 2);
    check("R11 wake to stop", {ulps_o, stop_o}, 1);
    check("R11 no error", seq_n - s0, 0);
    esc_enter(); send_byte(ULPS, 8);
    s0 = seq_n; put(2'b01, 2);
    check("R11 bad state in ulps", seq_n - s0, 1);
    go_stop();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule